// File: doc/BRIEF.md
# Write-Once Deferred-Read Array Memory

This block is a synchronising array store for producer/consumer hand-off. Each element starts empty and can be written exactly once. A consumer may read any element at any time, including before its producer has run. If the element already holds a value, the answer comes back on the response port on the next cycle, tagged with the consumer's identity. If the element has not been written yet, the request is parked in a shared pool of waiter entries and no answer is given. When the producer's value arrives, every parked consumer of that element receives it in turn. An array can therefore be passed to consumers while it is still being filled.

A second write to an element that already holds a value is illegal. It is discarded, the stored value is kept, and a sticky error output goes high. The write, read-request and response channels each use valid/ready handshakes. Parked readers are chained per element through the pool. Releasing them takes one response-port cycle per reader, and no other write or read is taken while that release is in progress.

Top module: `wo_defer_mem`

## Requirements
- R1: After a synchronous reset, every element is empty, `rsp_valid` and `wr_error` are 0, `wr_ready` is 1, and `rd_ready` is 1 while `wr_valid` is 0.
- R2: A read accepted on an element that holds a value produces `rsp_valid`=1 on the next cycle, with `rsp_tag` equal to the request's tag and `rsp_data` equal to the stored value.
- R3: A read accepted on an empty or waiting element produces no response and parks the request in the waiter pool.
- R4: A write accepted on an element with parked readers stores the value, and then sends one response per parked reader, each carrying that reader's tag and the new value. The most recently parked reader is answered first, and the first response appears two cycles after the write is accepted.
- R5: From the cycle after a write that releases waiters, until the cycle after the last waiter has been placed on the response port, `wr_ready` and `rd_ready` are 0.
- R6: A write accepted on an element that already holds a value leaves the value unchanged and sets `wr_error` on the next cycle. `wr_error` then stays 1 until reset.
- R7: The pool holds POOL parked reads, 16 by default. While all entries are in use `rd_ready` is 0, and an entry becomes free again when its reader is answered.
- R8: While `rsp_valid`=1 and `rsp_ready`=0, `rsp_tag` and `rsp_data` hold their values, and release of further waiters stalls.
- R9: Writes take priority: `rd_ready` is 0 in every cycle in which `wr_valid` is 1.
- R10: A write accepted on an empty element stores the value without producing a response, and later reads of that element return it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Write request present |
| wr_ready | output | 1 | Write request taken this cycle |
| wr_index | input | IDX_W (5) | Element to write |
| wr_data | input | DATA_W (16) | Value to store |
| rd_valid | input | 1 | Read request present |
| rd_ready | output | 1 | Read request taken this cycle |
| rd_index | input | IDX_W (5) | Element to read |
| rd_tag | input | TAG_W (4) | Requester identity returned with the value |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_tag | output | TAG_W (4) | Tag of the answered request |
| rsp_data | output | DATA_W (16) | Element value |
| wr_error | output | 1 | Sticky flag: a second write to a filled element was seen |

## Verification
Directed patterns separate the four cases of a request: a read after its write (immediate hit), reads parked before the write (release order and tag routing), a repeated write (error flag and preserved value), and a read that arrives together with a write (write priority). Filling the pool with parked reads to sixteen separate elements shows the back-pressure point and the point where it is released. Holding `rsp_ready` low during a release tells a stalled drain apart from a lost or duplicated response. Random mixed traffic between resets uses all elements and is compared cycle by cycle with a queue-based model. This exposes errors in chain linking, in entry reuse and in the handshake.

// File: rtl/wo_defer_pkg.sv
package wo_defer_pkg;

    // Presence state of one array element
    typedef enum logic [1:0] {
        CELL_EMPTY = 2'b00,
        CELL_WAIT  = 2'b01,
        CELL_FULL  = 2'b10
    } cell_st_e;

    // Controller mode
    typedef enum logic {
        CTL_RUN   = 1'b0,
        CTL_DRAIN = 1'b1
    } ctl_st_e;

    // What an accepted write does to its element
    typedef enum logic [1:0] {
        WR_STORE   = 2'b00,
        WR_RELEASE = 2'b01,
        WR_REJECT  = 2'b10
    } wr_kind_e;

    function automatic wr_kind_e classify_write(cell_st_e st);
        case (st)
            CELL_FULL: return WR_REJECT;
            CELL_WAIT: return WR_RELEASE;
            default:   return WR_STORE;
        endcase
    endfunction

    function automatic logic read_hits(cell_st_e st);
        return st == CELL_FULL;
    endfunction

endpackage

// File: rtl/wo_defer_pool.sv
module wo_defer_pool #(
    parameter int POOL  = 16,
    parameter int TAG_W = 4,
    localparam int PTR_W = (POOL > 1) ? $clog2(POOL) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             alloc_en,
    input  logic [TAG_W-1:0] alloc_tag,
    input  logic [PTR_W-1:0] alloc_next,
    input  logic             alloc_link,
    input  logic             rel_en,
    input  logic [PTR_W-1:0] rel_ptr,
    output logic             free_any,
    output logic [PTR_W-1:0] free_ptr,
    input  logic [PTR_W-1:0] look_ptr,
    output logic [TAG_W-1:0] look_tag,
    output logic [PTR_W-1:0] look_next,
    output logic             look_link
);
    typedef struct packed {
        logic [TAG_W-1:0] tag;
        logic [PTR_W-1:0] next;
        logic             link;
    } waiter_t;

    logic [POOL-1:0] busy_q;
    waiter_t         ent_q [POOL];

    // Lowest-numbered free entry
    always_comb begin
        free_ptr = '0;
        for (int i = POOL - 1; i >= 0; i--) begin
            if (!busy_q[i]) free_ptr = PTR_W'(i);
        end
    end

    assign free_any = ~&busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= '0;
        end else begin
            if (alloc_en) busy_q[free_ptr] <= 1'b1;
            if (rel_en)   busy_q[rel_ptr]  <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (alloc_en) begin
            ent_q[free_ptr] <= '{tag: alloc_tag, next: alloc_next, link: alloc_link};
        end
    end

    assign look_tag  = ent_q[look_ptr].tag;
    assign look_next = ent_q[look_ptr].next;
    assign look_link = ent_q[look_ptr].link;

endmodule

// File: rtl/wo_defer_cells.sv
module wo_defer_cells
    import wo_defer_pkg::*;
#(
    parameter int DEPTH  = 32,
    parameter int DATA_W = 16,
    parameter int PTR_W  = 4,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    // read-side lookup
    input  logic [IDX_W-1:0]  a_idx,
    output cell_st_e          a_st,
    output logic [DATA_W-1:0] a_data,
    output logic [PTR_W-1:0]  a_head,
    // write-side lookup
    input  logic [IDX_W-1:0]  b_idx,
    output cell_st_e          b_st,
    output logic [PTR_W-1:0]  b_head,
    // single update port
    input  logic              upd_en,
    input  logic [IDX_W-1:0]  upd_idx,
    input  cell_st_e          upd_st,
    input  logic              upd_data_en,
    input  logic [DATA_W-1:0] upd_data,
    input  logic              upd_head_en,
    input  logic [PTR_W-1:0]  upd_head
);
    cell_st_e          st_q   [DEPTH];
    logic [DATA_W-1:0] data_q [DEPTH];
    logic [PTR_W-1:0]  head_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) st_q[i] <= CELL_EMPTY;
        end else if (upd_en) begin
            st_q[upd_idx] <= upd_st;
        end
    end

    always_ff @(posedge clk) begin
        if (upd_en && upd_data_en) data_q[upd_idx] <= upd_data;
        if (upd_en && upd_head_en) head_q[upd_idx] <= upd_head;
    end

    assign a_st   = st_q[a_idx];
    assign a_data = data_q[a_idx];
    assign a_head = head_q[a_idx];
    assign b_st   = st_q[b_idx];
    assign b_head = head_q[b_idx];

endmodule

// File: rtl/wo_defer_rsp.sv
module wo_defer_rsp #(
    parameter int TAG_W  = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_en,
    input  logic [TAG_W-1:0]  load_tag,
    input  logic [DATA_W-1:0] load_data,
    input  logic              out_ready,
    output logic              slot_free,
    output logic              out_valid,
    output logic [TAG_W-1:0]  out_tag,
    output logic [DATA_W-1:0] out_data
);
    assign slot_free = !out_valid || out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_tag   <= '0;
            out_data  <= '0;
        end else if (load_en) begin
            out_valid <= 1'b1;
            out_tag   <= load_tag;
            out_data  <= load_data;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/wo_defer_mem.sv
module wo_defer_mem
    import wo_defer_pkg::*;
#(
    parameter int DEPTH  = 32,
    parameter int DATA_W = 16,
    parameter int TAG_W  = 4,
    parameter int POOL   = 16,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [IDX_W-1:0]  wr_index,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_valid,
    output logic              rd_ready,
    input  logic [IDX_W-1:0]  rd_index,
    input  logic [TAG_W-1:0]  rd_tag,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [TAG_W-1:0]  rsp_tag,
    output logic [DATA_W-1:0] rsp_data,
    output logic              wr_error
);
    localparam int PTR_W = (POOL > 1) ? $clog2(POOL) : 1;

    // controller state
    ctl_st_e           ctl_q;
    logic [PTR_W-1:0]  drain_ptr_q;
    logic [DATA_W-1:0] drain_data_q;
    logic              err_q;

    // element lookups
    cell_st_e          rd_cell_st;
    logic [DATA_W-1:0] rd_cell_data;
    logic [PTR_W-1:0]  rd_cell_head;
    cell_st_e          wr_cell_st;
    logic [PTR_W-1:0]  wr_cell_head;

    // element update
    logic              upd_en;
    logic [IDX_W-1:0]  upd_idx;
    cell_st_e          upd_st;
    logic              upd_data_en;
    logic              upd_head_en;

    // pool
    logic              pool_free_any;
    logic [PTR_W-1:0]  pool_free_ptr;
    logic              alloc_en;
    logic [TAG_W-1:0]  look_tag;
    logic [PTR_W-1:0]  look_next;
    logic              look_link;

    // response
    logic              rsp_free;
    logic              rsp_load;
    logic [TAG_W-1:0]  rsp_load_tag;
    logic [DATA_W-1:0] rsp_load_data;

    logic              draining;
    logic              wr_fire;
    logic              rd_fire;
    logic              rd_hit;
    logic              drain_step;
    wr_kind_e          wkind;

    assign draining   = (ctl_q == CTL_DRAIN);
    assign wr_ready   = !draining;
    assign rd_ready   = !draining && !wr_valid && pool_free_any && rsp_free;
    assign wr_fire    = wr_valid && wr_ready;
    assign rd_fire    = rd_valid && rd_ready;
    assign wkind      = classify_write(wr_cell_st);
    assign rd_hit     = read_hits(rd_cell_st);
    assign alloc_en   = rd_fire && !rd_hit;
    assign drain_step = draining && rsp_free;
    assign wr_error   = err_q;

    // element update selection: writes and reads never fire together
    always_comb begin
        upd_en      = 1'b0;
        upd_idx     = wr_index;
        upd_st      = CELL_FULL;
        upd_data_en = 1'b0;
        upd_head_en = 1'b0;
        if (wr_fire && wkind != WR_REJECT) begin
            upd_en      = 1'b1;
            upd_data_en = 1'b1;
        end else if (alloc_en) begin
            upd_en      = 1'b1;
            upd_idx     = rd_index;
            upd_st      = CELL_WAIT;
            upd_head_en = 1'b1;
        end
    end

    // response source selection
    always_comb begin
        rsp_load      = 1'b0;
        rsp_load_tag  = rd_tag;
        rsp_load_data = rd_cell_data;
        if (drain_step) begin
            rsp_load      = 1'b1;
            rsp_load_tag  = look_tag;
            rsp_load_data = drain_data_q;
        end else if (rd_fire && rd_hit) begin
            rsp_load = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q        <= CTL_RUN;
            drain_ptr_q  <= '0;
            drain_data_q <= '0;
            err_q        <= 1'b0;
        end else begin
            if (wr_fire && wkind == WR_REJECT) err_q <= 1'b1;
            case (ctl_q)
                CTL_RUN: begin
                    if (wr_fire && wkind == WR_RELEASE) begin
                        ctl_q        <= CTL_DRAIN;
                        drain_ptr_q  <= wr_cell_head;
                        drain_data_q <= wr_data;
                    end
                end
                CTL_DRAIN: begin
                    if (drain_step) begin
                        if (look_link) drain_ptr_q <= look_next;
                        else           ctl_q       <= CTL_RUN;
                    end
                end
                default: ctl_q <= CTL_RUN;
            endcase
        end
    end

    wo_defer_cells #(
        .DEPTH (DEPTH),
        .DATA_W(DATA_W),
        .PTR_W (PTR_W)
    ) u_cells (
        .clk        (clk),
        .rst        (rst),
        .a_idx      (rd_index),
        .a_st       (rd_cell_st),
        .a_data     (rd_cell_data),
        .a_head     (rd_cell_head),
        .b_idx      (wr_index),
        .b_st       (wr_cell_st),
        .b_head     (wr_cell_head),
        .upd_en     (upd_en),
        .upd_idx    (upd_idx),
        .upd_st     (upd_st),
        .upd_data_en(upd_data_en),
        .upd_data   (wr_data),
        .upd_head_en(upd_head_en),
        .upd_head   (pool_free_ptr)
    );

    wo_defer_pool #(
        .POOL (POOL),
        .TAG_W(TAG_W)
    ) u_pool (
        .clk       (clk),
        .rst       (rst),
        .alloc_en  (alloc_en),
        .alloc_tag (rd_tag),
        .alloc_next(rd_cell_head),
        .alloc_link(rd_cell_st == CELL_WAIT),
        .rel_en    (drain_step),
        .rel_ptr   (drain_ptr_q),
        .free_any  (pool_free_any),
        .free_ptr  (pool_free_ptr),
        .look_ptr  (drain_ptr_q),
        .look_tag  (look_tag),
        .look_next (look_next),
        .look_link (look_link)
    );

    wo_defer_rsp #(
        .TAG_W (TAG_W),
        .DATA_W(DATA_W)
    ) u_rsp (
        .clk      (clk),
        .rst      (rst),
        .load_en  (rsp_load),
        .load_tag (rsp_load_tag),
        .load_data(rsp_load_data),
        .out_ready(rsp_ready),
        .slot_free(rsp_free),
        .out_valid(rsp_valid),
        .out_tag  (rsp_tag),
        .out_data (rsp_data)
    );

endmodule

// File: rtl/wo_defer_chk.sv
module wo_defer_chk #(
    parameter int TAG_W  = 4,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_valid,
    input logic              wr_ready,
    input logic              rd_valid,
    input logic              rd_ready,
    input logic              rsp_valid,
    input logic              rsp_ready,
    input logic [TAG_W-1:0]  rsp_tag,
    input logic [DATA_W-1:0] rsp_data,
    input logic              wr_error,
    input logic              draining,
    input logic              pool_free_any
);
    AST_RSP_HOLD: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_tag) && $stable(rsp_data)); // R8

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        wr_error |=> wr_error); // R6

    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(wr_error) |-> $past(wr_valid && wr_ready)); // R6

    AST_WRITE_FIRST: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> !rd_ready); // R9

    AST_POOL_BLOCK: assert property (@(posedge clk) disable iff (rst)
        !pool_free_any |-> !rd_ready); // R7

    AST_DRAIN_ORIGIN: assert property (@(posedge clk) disable iff (rst)
        $rose(draining) |-> $past(wr_valid && wr_ready)); // R5

    AST_RSP_ORIGIN: assert property (@(posedge clk) disable iff (rst)
        $rose(rsp_valid) |-> $past(rd_valid && rd_ready) || $past(!wr_ready)); // R2

endmodule

bind wo_defer_mem wo_defer_chk #(
    .TAG_W (TAG_W),
    .DATA_W(DATA_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .wr_valid     (wr_valid),
    .wr_ready     (wr_ready),
    .rd_valid     (rd_valid),
    .rd_ready     (rd_ready),
    .rsp_valid    (rsp_valid),
    .rsp_ready    (rsp_ready),
    .rsp_tag      (rsp_tag),
    .rsp_data     (rsp_data),
    .wr_error     (wr_error),
    .draining     (draining),
    .pool_free_any(pool_free_any)
);

// File: tb/wo_defer_mem_test.sv
`timescale 1ns/1ps
module wo_defer_mem_test;
    localparam int DEPTH  = 32;
    localparam int DATA_W = 16;
    localparam int TAG_W  = 4;
    localparam int POOL   = 16;
    localparam int IDX_W  = 5;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_valid = 1'b0;
    logic              wr_ready;
    logic [IDX_W-1:0]  wr_index = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              rd_valid = 1'b0;
    logic              rd_ready;
    logic [IDX_W-1:0]  rd_index = '0;
    logic [TAG_W-1:0]  rd_tag = '0;
    logic              rsp_valid;
    logic              rsp_ready = 1'b1;
    logic [TAG_W-1:0]  rsp_tag;
    logic [DATA_W-1:0] rsp_data;
    logic              wr_error;

    always #2.5 clk = ~clk;

    wo_defer_mem #(.DEPTH(DEPTH), .DATA_W(DATA_W), .TAG_W(TAG_W), .POOL(POOL)) uut (
        .clk(clk), .rst(rst),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_index(wr_index), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_index(rd_index), .rd_tag(rd_tag),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_tag(rsp_tag), .rsp_data(rsp_data),
        .wr_error(wr_error)
    );

    int checks = 0;
    int errors = 0;

    // behavioural reference: 0 empty, 1 waiting, 2 full
    int m_st  [DEPTH];
    int m_dat [DEPTH];
    int w_idx [$];
    int w_tag [$];
    int d_tag [$];
    int d_data;
    bit m_rv;
    int m_rt, m_rd;
    bit m_err;
    bit e_wr_rdy, e_rd_rdy, f_wr, f_rd;

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic model_init();
        for (int i = 0; i < DEPTH; i++) begin
            m_st[i] = 0;
            m_dat[i] = 0;
        end
        w_idx.delete(); w_tag.delete(); d_tag.delete();
        d_data = 0; m_rv = 0; m_rt = 0; m_rd = 0; m_err = 0;
    endtask

    task automatic compare_all();
        e_wr_rdy = (d_tag.size() == 0);
        e_rd_rdy = e_wr_rdy && !wr_valid && (w_idx.size() < POOL) && (!m_rv || rsp_ready);
        chk(wr_ready === e_wr_rdy, "R5 wr_ready", int'(wr_ready), int'(e_wr_rdy));
        chk(rd_ready === e_rd_rdy, "R7 R9 rd_ready", int'(rd_ready), int'(e_rd_rdy));
        chk(rsp_valid === m_rv, "R3 R4 rsp_valid", int'(rsp_valid), int'(m_rv));
        if (m_rv) begin
            chk(int'(rsp_tag) == m_rt, "R2 R4 R8 rsp_tag", int'(rsp_tag), m_rt);
            chk(int'(rsp_data) == m_rd, "R2 R4 R8 rsp_data", int'(rsp_data), m_rd);
        end
        chk(wr_error === m_err, "R6 wr_error", int'(wr_error), int'(m_err));
        f_wr = wr_valid && e_wr_rdy;
        f_rd = rd_valid && e_rd_rdy;
    endtask

    task automatic model_update();
        bit free;
        free = !m_rv || rsp_ready;
        if (m_rv && rsp_ready) m_rv = 0;
        if (d_tag.size() > 0) begin
            if (free) begin
                m_rv = 1; m_rt = d_tag.pop_front(); m_rd = d_data;
            end
        end else if (f_rd) begin
            if (m_st[rd_index] == 2) begin
                m_rv = 1; m_rt = int'(rd_tag); m_rd = m_dat[rd_index];
            end else begin
                w_idx.push_back(int'(rd_index));
                w_tag.push_back(int'(rd_tag));
                m_st[rd_index] = 1;
            end
        end
        if (f_wr) begin
            if (m_st[wr_index] == 2) begin
                m_err = 1;
            end else begin
                if (m_st[wr_index] == 1) begin
                    for (int k = w_idx.size() - 1; k >= 0; k--) begin
                        if (w_idx[k] == int'(wr_index)) begin
                            d_tag.push_back(w_tag[k]);
                            w_idx.delete(k);
                            w_tag.delete(k);
                        end
                    end
                    d_data = int'(wr_data);
                end
                m_dat[wr_index] = int'(wr_data);
                m_st[wr_index] = 2;
            end
        end
    endtask

    // called at a falling edge with inputs already driven
    task automatic tick();
        #1;
        compare_all();
        @(posedge clk);
        model_update();
        @(negedge clk);
    endtask

    task automatic cyc(input bit wv, input int wi, input int wd,
                       input bit rv, input int ri, input int rt, input bit rr);
        wr_valid = wv; wr_index = IDX_W'(wi); wr_data = DATA_W'(wd);
        rd_valid = rv; rd_index = IDX_W'(ri); rd_tag = TAG_W'(rt);
        rsp_ready = rr;
        tick();
    endtask

    task automatic idle(input bit rr);
        cyc(0, 0, 0, 0, 0, 0, rr);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        wr_valid = 0; rd_valid = 0; rsp_ready = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_init();
        #1;
        chk(rsp_valid === 1'b0, "R1 rsp_valid after reset", int'(rsp_valid), 0);
        chk(wr_error === 1'b0, "R1 wr_error after reset", int'(wr_error), 0);
        chk(wr_ready === 1'b1, "R1 wr_ready after reset", int'(wr_ready), 1);
        chk(rd_ready === 1'b1, "R1 rd_ready after reset", int'(rd_ready), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        do_reset();
        @(negedge clk);

        // R10: write into an empty element, no response, later read hits
        cyc(1, 2, 16'h1234, 0, 0, 0, 1);
        chk(rsp_valid === 1'b0, "R10 no response to plain write", int'(rsp_valid), 0);
        cyc(0, 0, 0, 1, 2, 7, 1);
        chk(rsp_valid === 1'b1 && rsp_tag == 4'd7, "R2 hit tag next cycle", int'(rsp_tag), 7);
        chk(rsp_data == 16'h1234, "R10 stored value returned", int'(rsp_data), 16'h1234);

        // R3: park three readers on element 9
        cyc(0, 0, 0, 1, 9, 1, 1);
        cyc(0, 0, 0, 1, 9, 2, 1);
        cyc(0, 0, 0, 1, 9, 3, 1);
        idle(1);
        chk(rsp_valid === 1'b0, "R3 parked reads give no response", int'(rsp_valid), 0);

        // R4/R5: release in most-recent-first order, ports blocked meanwhile
        cyc(1, 9, 16'hBEEF, 0, 0, 0, 1);
        chk(wr_ready === 1'b0, "R5 writes blocked during release", int'(wr_ready), 0);
        idle(1);
        chk(rsp_valid && rsp_tag == 4'd3, "R4 first released tag", int'(rsp_tag), 3);
        chk(rsp_data == 16'hBEEF, "R4 released value", int'(rsp_data), 16'hBEEF);
        idle(1);
        chk(rsp_valid && rsp_tag == 4'd2, "R4 second released tag", int'(rsp_tag), 2);
        idle(1);
        chk(rsp_valid && rsp_tag == 4'd1, "R4 third released tag", int'(rsp_tag), 1);
        chk(wr_ready === 1'b1, "R5 writes reopen after last waiter", int'(wr_ready), 1);
        idle(1);

        // R8: back-pressure during a release
        cyc(0, 0, 0, 1, 11, 4, 1);
        cyc(0, 0, 0, 1, 11, 5, 1);
        cyc(1, 11, 16'h00AA, 0, 0, 0, 0);
        idle(0);
        idle(0);
        idle(0);
        chk(rsp_valid && rsp_tag == 4'd5, "R8 held response tag", int'(rsp_tag), 5);
        chk(wr_ready === 1'b0, "R8 release stalled", int'(wr_ready), 0);
        idle(1);
        chk(rsp_valid && rsp_tag == 4'd4, "R8 next tag after accept", int'(rsp_tag), 4);
        idle(1);
        idle(1);

        // R6: second write is refused and flagged
        cyc(1, 2, 16'h5555, 0, 0, 0, 1);
        chk(wr_error === 1'b1, "R6 error flag raised", int'(wr_error), 1);
        cyc(0, 0, 0, 1, 2, 9, 1);
        chk(rsp_data == 16'h1234, "R6 value unchanged", int'(rsp_data), 16'h1234);
        idle(1);
        idle(1);
        chk(wr_error === 1'b1, "R6 error flag sticky", int'(wr_error), 1);

        // R9: write has priority over a read in the same cycle
        wr_valid = 1; wr_index = 5'd4; wr_data = 16'h0404;
        rd_valid = 1; rd_index = 5'd2; rd_tag = 4'd1; rsp_ready = 1;
        #1;
        chk(rd_ready === 1'b0, "R9 read held off by write", int'(rd_ready), 0);
        tick();

        // R7: fill the pool with parked reads
        for (int i = 0; i < POOL; i++) cyc(0, 0, 0, 1, 16 + i, i, 1);
        rd_valid = 1; rd_index = 5'd0; wr_valid = 0;
        #1;
        chk(rd_ready === 1'b0, "R7 pool exhausted", int'(rd_ready), 0);
        tick();
        cyc(1, 16, 16'h0016, 0, 0, 0, 1);
        idle(1);
        chk(rsp_valid && rsp_tag == 4'd0, "R7 released entry tag", int'(rsp_tag), 0);
        chk(rd_ready === 1'b1, "R7 pool entry reusable", int'(rd_ready), 1);

        // mixed random traffic with resets between rounds
        for (int r = 0; r < 4; r++) begin
            do_reset();
            @(negedge clk);
            for (int n = 0; n < 700; n++) begin
                cyc(($urandom % 4) == 0, int'($urandom % DEPTH), int'($urandom % 65536),
                    ($urandom % 3) != 0, int'($urandom % DEPTH), int'($urandom % 16),
                    ($urandom % 4) != 0);
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule